// File: doc/BRIEF.md
# Asynchronous Byte-Framed Receive Status Unit

This block receives one asynchronous serial line that carries 8-bit characters with one start bit, no parity and one stop bit. It places each good character in a single holding register for the host. It also watches the character stream for the frame delimiter 0x7E and the escape byte 0x7D. From these it tracks one status byte per frame, so a host running PPP-style or SLIP-style framing learns how each frame ended and whether any line errors occurred during it.

Line errors do not interrupt the host one character at a time. Overrun and break are collected over the whole frame. They are copied into the readable status byte together with the end cause when the frame closes. A framing error closes the frame at once as an aborted frame. Each frame close raises a pending request. The request reaches the interrupt pin only while the receive-data interrupt enable is high, and it stays pending until the host acknowledges it.

Top module: `pppRxStatus`

## Requirements
- R1: The line is sampled 16 times per bit. A low level is accepted as a start bit only if it is still low at the middle of the bit, so a low pulse shorter than half a bit is ignored. The 8 data bits are sampled at their bit centres, least significant bit first. A good character appears on `rxByte` with `rxByteValid` high, and a one-cycle `rxByteRead` clears `rxByteValid`.
- R2: If the stop bit samples 0 and the data is not all zeros, this is a framing error. The character is discarded and the frame ends as aborted, with status bit 5 = 1 and bit 2 = 1.
- R3: A character whose start, data and stop bits are all 0 is a break. A break sets the sticky status bit 0 and does not end the frame. The receiver accepts a new start bit only after the line has been high for one full bit time.
- R4: A 0x7E that does not directly follow a 0x7D ends the frame normally: status bit 6 = 1 and bit 5 = 0. A 0x7D followed by some other byte and then 0x7E is still a normal end.
- R5: A 0x7D directly followed by 0x7E ends the frame as aborted: bit 5 = 1, bit 2 = 0, bit 6 = 0.
- R6: If a character completes while the holding register is full and is not being read in that cycle, the new character is dropped, the held character is kept, and sticky status bit 3 (overrun) is set.
- R7: Overrun and break build up until the frame ends. They are then copied into the status byte, and their accumulators are cleared. The status byte changes only when a frame ends. Bits 7, 4 and 1 always read 0. The combination bit 5 = 0 with bit 2 = 1 never appears. The reset value is 0x00.
- R8: `frameEnd` pulses high for exactly one cycle for each frame end: a normal end, an escape abort or a framing-error abort.
- R9: `statusIrq` equals a pending flag ANDed with `rxDataIntEn`. A frame end sets the flag. `statusAck` clears it, except that a frame end in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxSerial | input | 1 | Asynchronous serial receive line, idles high |
| rxDataIntEn | input | 1 | Receive-data interrupt enable |
| statusAck | input | 1 | Host acknowledge of the frame status request |
| rxByteRead | input | 1 | Host read strobe for the holding register |
| rxByte | output | 8 | Holding register contents |
| rxByteValid | output | 1 | Holding register contains an unread character |
| frameEnd | output | 1 | One-cycle pulse at each frame end |
| statusByte | output | 8 | Latched frame status: bit6 end, bit5 abort, bit3 overrun, bit2 framing, bit0 break |
| statusIrq | output | 1 | Status interrupt request |

## Verification
Each sticky or escape state that is wrong inside the block shows up at the next frame end, in the status byte the host reads. An overrun or break accumulator that is not cleared appears as a stray bit 3 or bit 0 in the following frame. A stale escape flag turns a normal close into an abort code. An error in the receiver's bit timing shows one character later, as a wrong `rxByte` or a missing `rxByteValid`. A fault in the pending-request logic shows within one cycle of a frame end or acknowledge, on `statusIrq` and `frameEnd`.

// File: rtl/pppRxPkg.sv
package pppRxPkg;

  localparam logic [7:0] FLAG_CHAR = 8'h7E;
  localparam logic [7:0] ESC_CHAR  = 8'h7D;

  // status byte bit positions (host decodes these)
  localparam int ST_END   = 6;
  localparam int ST_ABORT = 5;
  localparam int ST_OVR   = 3;
  localparam int ST_FRAME = 2;
  localparam int ST_BREAK = 0;

  typedef struct packed {
    logic shiftEn;   // shift one data bit in
    logic shiftBit;  // the bit value to shift
    logic byteDone;  // well-framed character complete
    logic setBrk;    // break seen
    logic endEof;    // normal frame close
    logic endAbort;  // escape-flag abort
    logic endFe;     // framing-error abort
  } rxStrobeT;

endpackage

// File: rtl/pppRxCtrl.sv
module pppRxCtrl
  import pppRxPkg::*;
#(
  parameter int OVS          = 16,
  parameter int CLK_PER_TICK = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxSerial,
  input  logic [7:0] shiftData,
  output rxStrobeT   strb
);

  localparam int CNT_W = $clog2(OVS);
  localparam int DIV_W = $clog2(CLK_PER_TICK) + 1;
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVS - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_TICK - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_RECOVER} stateT;

  logic [1:0]       syncQ;
  logic             rxBit;
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  stateT            state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [2:0]       bitIdx, bitIdxN;
  logic             escSeen, escSeenN;

  assign rxBit = syncQ[1];
  assign tick  = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      divCnt <= '0;
    end else begin
      syncQ  <= {syncQ[0], rxSerial};
      divCnt <= tick ? '0 : divCnt + 1'b1;
    end
  end

  always_comb begin
    stateN   = state;
    cntN     = cnt;
    bitIdxN  = bitIdx;
    escSeenN = escSeen;
    strb     = '0;
    if (tick) begin
      unique case (state)
        S_IDLE: begin
          if (!rxBit) begin
            stateN = S_START;
            cntN   = '0;
          end
        end
        S_START: begin
          if (cnt == HALF_CNT) begin
            cntN    = '0;
            bitIdxN = '0;
            stateN  = rxBit ? S_IDLE : S_DATA;
          end else begin
            cntN = cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt == FULL_CNT) begin
            strb.shiftEn  = 1'b1;
            strb.shiftBit = rxBit;
            cntN          = '0;
            bitIdxN       = bitIdx + 1'b1;
            if (bitIdx == 3'd7) stateN = S_STOP;
          end else begin
            cntN = cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt == FULL_CNT) begin
            cntN = '0;
            if (rxBit) begin
              strb.byteDone = 1'b1;
              stateN        = S_IDLE;
              if (shiftData == FLAG_CHAR) begin
                strb.endAbort = escSeen;
                strb.endEof   = !escSeen;
                escSeenN      = 1'b0;
              end else begin
                escSeenN = (shiftData == ESC_CHAR);
              end
            end else begin
              escSeenN = 1'b0;
              stateN   = S_RECOVER;
              if (shiftData == 8'h00) strb.setBrk = 1'b1;
              else                    strb.endFe  = 1'b1;
            end
          end else begin
            cntN = cnt + 1'b1;
          end
        end
        S_RECOVER: begin
          if (!rxBit) begin
            cntN = '0;
          end else if (cnt == FULL_CNT) begin
            cntN   = '0;
            stateN = S_IDLE;
          end else begin
            cntN = cnt + 1'b1;
          end
        end
        default: stateN = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      escSeen <= 1'b0;
    end else begin
      state   <= stateN;
      cnt     <= cntN;
      bitIdx  <= bitIdxN;
      escSeen <= escSeenN;
    end
  end

endmodule

// File: rtl/pppRxData.sv
module pppRxData
  import pppRxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobeT   strb,
  input  logic       rxByteRead,
  input  logic       statusAck,
  output logic [7:0] shiftData,
  output logic [7:0] rxByte,
  output logic       rxByteValid,
  output logic [7:0] statusByte,
  output logic       irqPending,
  output logic       frameEnd
);

  logic [7:0] shiftReg, holdReg, statusReg, statusN;
  logic       holdValid, oeAcc, brkAcc;
  logic       accept, ovNow, anyEnd, oeNext, brkNext;

  assign shiftData   = shiftReg;
  assign rxByte      = holdReg;
  assign rxByteValid = holdValid;
  assign statusByte  = statusReg;

  assign accept  = strb.byteDone && (!holdValid || rxByteRead);
  assign ovNow   = strb.byteDone && holdValid && !rxByteRead;
  assign anyEnd  = strb.endEof || strb.endAbort || strb.endFe;
  assign oeNext  = oeAcc || ovNow;
  assign brkNext = brkAcc || strb.setBrk;

  always_comb begin
    statusN           = '0;
    statusN[ST_END]   = strb.endEof;
    statusN[ST_ABORT] = strb.endAbort || strb.endFe;
    statusN[ST_FRAME] = strb.endFe;
    statusN[ST_OVR]   = oeNext;
    statusN[ST_BREAK] = brkNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      holdReg    <= '0;
      holdValid  <= 1'b0;
      statusReg  <= '0;
      oeAcc      <= 1'b0;
      brkAcc     <= 1'b0;
      irqPending <= 1'b0;
      frameEnd   <= 1'b0;
    end else begin
      if (strb.shiftEn) shiftReg <= {strb.shiftBit, shiftReg[7:1]};
      if (accept) begin
        holdReg   <= shiftReg;
        holdValid <= 1'b1;
      end else if (rxByteRead) begin
        holdValid <= 1'b0;
      end
      frameEnd <= anyEnd;
      if (anyEnd) begin
        statusReg  <= statusN;
        oeAcc      <= 1'b0;
        brkAcc     <= 1'b0;
        irqPending <= 1'b1;
      end else begin
        oeAcc  <= oeNext;
        brkAcc <= brkNext;
        if (statusAck) irqPending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pppRxStatus.sv
module pppRxStatus
  import pppRxPkg::*;
#(
  parameter int OVS          = 16,
  parameter int CLK_PER_TICK = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxSerial,
  input  logic       rxDataIntEn,
  input  logic       statusAck,
  input  logic       rxByteRead,
  output logic [7:0] rxByte,
  output logic       rxByteValid,
  output logic       frameEnd,
  output logic [7:0] statusByte,
  output logic       statusIrq
);

  rxStrobeT   strb;
  logic [7:0] shiftData;
  logic       irqPending;

  pppRxCtrl #(.OVS(OVS), .CLK_PER_TICK(CLK_PER_TICK)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxSerial  (rxSerial),
    .shiftData (shiftData),
    .strb      (strb)
  );

  pppRxData i_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rxByteRead  (rxByteRead),
    .statusAck   (statusAck),
    .shiftData   (shiftData),
    .rxByte      (rxByte),
    .rxByteValid (rxByteValid),
    .statusByte  (statusByte),
    .irqPending  (irqPending),
    .frameEnd    (frameEnd)
  );

  assign statusIrq = irqPending && rxDataIntEn;

endmodule

// File: rtl/pppRxStatusChk.sv
module pppRxStatusChk (
  input logic       clk,
  input logic       rstN,
  input logic       rxDataIntEn,
  input logic       statusAck,
  input logic       rxByteRead,
  input logic [7:0] rxByte,
  input logic       rxByteValid,
  input logic       frameEnd,
  input logic [7:0] statusByte,
  input logic       statusIrq
);

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[7] == 1'b0) && (statusByte[4] == 1'b0) && (statusByte[1] == 1'b0));

  a_r7_no_unused_code: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[5] == 1'b0 && statusByte[2] == 1'b1));

  a_r5_end_abort_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[6] && statusByte[5]));

  a_r7_status_stable: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |-> $stable(statusByte));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !frameEnd);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    statusIrq |-> rxDataIntEn);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusAck && !frameEnd) |=> (!statusIrq || frameEnd));

  a_r9_rise_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (rxDataIntEn && $past(rxDataIntEn) && $rose(statusIrq)) |-> frameEnd);

  a_r1_hold_kept: assert property (@(posedge clk) disable iff (!rstN)
    (rxByteValid && !rxByteRead) |=> (rxByteValid && $stable(rxByte)));

endmodule

bind pppRxStatus pppRxStatusChk i_pppRxStatusChk (.*);

// File: tb/test_pppRxStatus.sv
module test_pppRxStatus;

  localparam int OVS  = 16;
  localparam int CPT  = 2;
  localparam int BIT  = OVS * CPT;
  localparam int GAP  = 3 * BIT;

  typedef struct packed {
    logic [7:0] ch;
    logic       stopBit;
    logic       doRead;
    logic       expValid;
    logic [7:0] expByte;
    logic [7:0] expStatus;
    logic       expIrq;
  } vecT;

  localparam int NVEC = 14;
  localparam vecT VEC [NVEC] = '{
    '{8'h11, 1'b1, 1'b1, 1'b1, 8'h11, 8'h00, 1'b0},  // R1 plain byte
    '{8'h7E, 1'b1, 1'b1, 1'b1, 8'h7E, 8'h40, 1'b1},  // R4 normal end
    '{8'h22, 1'b1, 1'b1, 1'b1, 8'h22, 8'h40, 1'b0},  // R7 status held
    '{8'h7D, 1'b1, 1'b1, 1'b1, 8'h7D, 8'h40, 1'b0},
    '{8'h7E, 1'b1, 1'b1, 1'b1, 8'h7E, 8'h20, 1'b1},  // R5 escape abort
    '{8'h7D, 1'b1, 1'b1, 1'b1, 8'h7D, 8'h20, 1'b0},
    '{8'h41, 1'b1, 1'b1, 1'b1, 8'h41, 8'h20, 1'b0},
    '{8'h7E, 1'b1, 1'b1, 1'b1, 8'h7E, 8'h40, 1'b1},  // R4 escape not adjacent
    '{8'h33, 1'b1, 1'b0, 1'b1, 8'h33, 8'h40, 1'b0},
    '{8'h44, 1'b1, 1'b0, 1'b1, 8'h33, 8'h40, 1'b0},  // R6 overrun, 0x33 kept
    '{8'h7E, 1'b1, 1'b1, 1'b1, 8'h33, 8'h48, 1'b1},  // R6 overrun reported
    '{8'h55, 1'b1, 1'b1, 1'b1, 8'h55, 8'h48, 1'b0},
    '{8'h66, 1'b0, 1'b0, 1'b0, 8'h00, 8'h24, 1'b1},  // R2 framing abort
    '{8'h7E, 1'b1, 1'b1, 1'b1, 8'h7E, 8'h40, 1'b1}   // R7 accumulators cleared
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxSerial = 1'b1;
  logic       rxDataIntEn = 1'b1;
  logic       statusAck = 1'b0;
  logic       rxByteRead = 1'b0;
  logic [7:0] rxByte;
  logic       rxByteValid;
  logic       frameEnd;
  logic [7:0] statusByte;
  logic       statusIrq;

  int checks = 0;
  int fails  = 0;
  int endCycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pppRxStatus #(.OVS(OVS), .CLK_PER_TICK(CPT)) i_pppRxStatus (
    .clk(clk), .rstN(rstN), .rxSerial(rxSerial), .rxDataIntEn(rxDataIntEn),
    .statusAck(statusAck), .rxByteRead(rxByteRead), .rxByte(rxByte),
    .rxByteValid(rxByteValid), .frameEnd(frameEnd), .statusByte(statusByte),
    .statusIrq(statusIrq)
  );

  always @(posedge clk) if (rstN && frameEnd) endCycles <= endCycles + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] d, input logic stopBit);
    rxSerial = 1'b0;
    waitClk(BIT);
    for (int i = 0; i < 8; i++) begin
      rxSerial = d[i];
      waitClk(BIT);
    end
    rxSerial = stopBit;
    waitClk(BIT);
    rxSerial = 1'b1;
    waitClk(4);
  endtask

  task automatic pulseRead();
    rxByteRead = 1'b1;
    waitClk(1);
    rxByteRead = 1'b0;
    waitClk(1);
  endtask

  task automatic pulseAck();
    statusAck = 1'b1;
    waitClk(1);
    statusAck = 1'b0;
    waitClk(1);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    // reset state
    check("R7 reset status", statusByte, 8'h00);
    check("R9 reset irq", statusIrq, 1'b0);
    check("R1 reset valid", rxByteValid, 1'b0);
    check("R8 reset frameEnd", frameEnd, 1'b0);

    // R1: short low glitch is not a start bit
    rxSerial = 1'b0;
    waitClk(3 * CPT);
    rxSerial = 1'b1;
    waitClk(GAP);
    check("R1 glitch ignored", rxByteValid, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      sendChar(VEC[v].ch, VEC[v].stopBit);
      check("R7 vector status", statusByte, VEC[v].expStatus);
      check("R9 vector irq", statusIrq, VEC[v].expIrq);
      check("R1 vector valid", rxByteValid, VEC[v].expValid);
      if (VEC[v].expValid) check("R1 vector byte", rxByte, VEC[v].expByte);
      if (VEC[v].doRead) begin
        pulseRead();
        check("R1 read clears valid", rxByteValid, 1'b0);
      end
      if (VEC[v].expIrq) begin
        pulseAck();
        check("R9 ack clears irq", statusIrq, 1'b0);
      end
      waitClk(GAP);
    end

    // R3: break, then recovery and a new frame
    rxSerial = 1'b0;
    waitClk(12 * BIT);
    rxSerial = 1'b1;
    waitClk(2 * BIT);
    check("R3 break no irq", statusIrq, 1'b0);
    check("R3 break no frame end", statusByte, 8'h40);
    sendChar(8'h5A, 1'b1);
    check("R3 rearm valid", rxByteValid, 1'b1);
    check("R3 rearm byte", rxByte, 8'h5A);
    pulseRead();
    waitClk(GAP);
    sendChar(8'h7E, 1'b1);
    check("R3 break sticky in status", statusByte, 8'h41);
    check("R3 irq at end", statusIrq, 1'b1);
    pulseRead();
    pulseAck();
    waitClk(GAP);

    // R9: interrupt gating
    rxDataIntEn = 1'b0;
    sendChar(8'h7E, 1'b1);
    check("R4 status clean end", statusByte, 8'h40);
    check("R9 gated irq low", statusIrq, 1'b0);
    rxDataIntEn = 1'b1;
    waitClk(1);
    check("R9 pending shows on enable", statusIrq, 1'b1);
    pulseAck();
    check("R9 ack after enable", statusIrq, 1'b0);
    pulseRead();

    // R8: one cycle per frame end (6 table + 2 directed)
    check("R8 frameEnd cycles", endCycles, 8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule